// File: doc/BRIEF.md
# Accumulator Execute Unit with Result Routing

This block is the 8-bit data path of a processor built around one accumulator. For each instruction it gets the current accumulator byte, an immediate byte, the byte read from a 128-entry register file, a small operation code and a routing bit. It computes a result byte and decides whether that byte goes back to the accumulator or to the register file entry it came from. It also produces candidate values for the carry, half-carry and zero flags, together with an update enable for each flag. The result path is combinational. The three flags are held in registers and change on a clock edge when the execute strobe is high.

The block has five operations. Two subtract the accumulator: one from the immediate byte and one from the register operand. Two rotate the register operand through the stored carry, one to the left and one to the right. The fifth exchanges the two nibbles of the register operand. Each operation touches its own set of flags. The register-file storage, fetch and opcode decode are outside the block. The caller presents the byte it read at `src_idx` on `rf_rdata` and writes `result` back when `rf_we` is high.

Top module: `accx_unit`

## Requirements
- R1: Operation code 0 (immediate subtract) gives `result` = `imm_val` − `acc_val` modulo 256. Under `exec_en` it asserts `acc_we` and never `rf_we`, whatever `to_rf` is.
- R2: Operation code 1 (register subtract) gives `result` = `rf_rdata` − `acc_val` modulo 256. Under `exec_en`, `to_rf`=0 asserts `acc_we` and `to_rf`=1 asserts `rf_we`. The two write enables are never high together.
- R3: After either subtraction, the carry flag is 1 when the minuend is greater than or equal to the subtrahend (no borrow out of bit 7) and 0 otherwise.
- R4: After either subtraction, the half-carry flag is 1 when the minuend's bits 3:0 are greater than or equal to the subtrahend's bits 3:0, and 0 otherwise.
- R5: After either subtraction, the zero flag is 1 exactly when the 8-bit result is zero.
- R6: Operation code 2 (rotate left) gives `result` = {`rf_rdata`[6:0], stored carry}. The new carry is `rf_rdata`[7]. The half-carry and zero flags are left unchanged. The destination follows `to_rf`.
- R7: Operation code 3 (rotate right) gives `result` = {stored carry, `rf_rdata`[7:1]}. The new carry is `rf_rdata`[0]. The half-carry and zero flags are left unchanged. The destination follows `to_rf`.
- R8: Operation code 4 (nibble exchange) gives `result` = {`rf_rdata`[3:0], `rf_rdata`[7:4]}. It leaves all three flags unchanged. The destination follows `to_rf`.
- R9: All flags read 0 after reset. A flag changes only on a clock edge where `exec_en` is high and that flag's update enable is high.
- R10: Operation codes 5 to 7, and any cycle with `exec_en` low, raise neither write enable and change no flag.
- R11: `rf_waddr` always equals `src_idx`, so a register write-back lands on the entry that was read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Execute strobe; enables writes and flag updates |
| op_code | input | 3 | Operation select (0..4 valid) |
| to_rf | input | 1 | Routing bit: 0 accumulator, 1 register file |
| acc_val | input | 8 | Current accumulator value |
| imm_val | input | 8 | Immediate operand |
| src_idx | input | 7 | Register-file index of the operand |
| rf_rdata | input | 8 | Register-file byte read at src_idx |
| result | output | 8 | Computed result byte |
| acc_we | output | 1 | Write result to accumulator |
| rf_we | output | 1 | Write result to register file |
| rf_waddr | output | 7 | Register-file write index |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_dc | output | 1 | Stored half-carry flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The hardest case to reach from the ports is a rotate whose outcome depends on a carry left behind by an earlier, different instruction. This matters most when a swap or an illegal code sits in between and must not disturb that carry. The directed sequences first set the carry with a subtraction that borrows or does not borrow. They then run rotates back to back, so each rotate feeds the next through the stored carry. Nibble exchanges and reserved codes are placed between them. The accumulator is steered to chosen values through immediate subtraction, which lets the minuend-equals-subtrahend and nibble-boundary cases be hit exactly.

// File: rtl/accx_pkg.sv
// Shared types for the accumulator execute unit.
// Assumes a 3-bit operation code; codes above OP_SWAP are reserved.
package accx_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;

    typedef enum logic [2:0] {
        OP_SUBI = 3'd0,
        OP_SUBR = 3'd1,
        OP_ROTL = 3'd2,
        OP_ROTR = 3'd3,
        OP_SWAP = 3'd4
    } accx_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } accx_flags_t;
endpackage

// File: rtl/accx_sub.sv
// Two's complement subtractor: diff = min - sub.
// Produces the no-borrow carry out of the top bit and out of the low
// nibble, plus a zero detect. Purely combinational; assumes DATA_W >= 8.
module accx_sub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] min_i,
    input  logic [DATA_W-1:0] sub_i,
    output logic [DATA_W-1:0] diff_o,
    output logic              nb_full_o,
    output logic              nb_half_o,
    output logic              zero_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   half_sum;

    // Full-width add of the inverted subtrahend plus one.
    always_comb begin
        full_sum = {1'b0, min_i} + {1'b0, ~sub_i} + {{DATA_W{1'b0}}, 1'b1};
    end

    // Low-nibble add for the half-carry.
    always_comb begin
        half_sum = {1'b0, min_i[HALF_W-1:0]} + {1'b0, ~sub_i[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, 1'b1};
    end

    assign diff_o    = full_sum[DATA_W-1:0];
    assign nb_full_o = full_sum[DATA_W];
    assign nb_half_o = half_sum[HALF_W];
    assign zero_o    = (full_sum[DATA_W-1:0] == '0);
endmodule

// File: rtl/accx_shift.sv
// Rotate-through-carry and nibble exchange on one byte.
// mode_i: 0 rotate left, 1 rotate right, 2 nibble swap. Combinational.
module accx_shift #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              cin_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int HALF_W = DATA_W / 2;

    // Select one of the three bit permutations.
    always_comb begin
        res_o  = src_i;
        cout_o = cin_i;
        case (mode_i)
            2'd0: begin
                res_o  = {src_i[DATA_W-2:0], cin_i};
                cout_o = src_i[DATA_W-1];
            end
            2'd1: begin
                res_o  = {cin_i, src_i[DATA_W-1:1]};
                cout_o = src_i[0];
            end
            2'd2: begin
                res_o  = {src_i[HALF_W-1:0], src_i[DATA_W-1:HALF_W]};
                cout_o = cin_i;
            end
            default: begin
                res_o  = src_i;
                cout_o = cin_i;
            end
        endcase
    end
endmodule

// File: rtl/accx_flags.sv
// Flag storage: each flag loads its candidate on a strobed edge when its
// own update enable is high. Synchronous active-low reset clears all.
module accx_flags (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb_i,
    input  accx_pkg::accx_flags_t nxt_i,
    input  accx_pkg::accx_flags_t upd_i,
    output accx_pkg::accx_flags_t cur_o
);
    // Per-flag conditional load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= '0;
        end else if (stb_i) begin
            if (upd_i.c)  cur_o.c  <= nxt_i.c;
            if (upd_i.dc) cur_o.dc <= nxt_i.dc;
            if (upd_i.z)  cur_o.z  <= nxt_i.z;
        end
    end
endmodule

// File: rtl/accx_unit.sv
// Accumulator execute unit top. Selects the operation, routes the result
// to accumulator or register file, and keeps the flags. Assumes the caller
// presents rf_rdata for src_idx in the same cycle.
module accx_unit #(
    parameter int DATA_W = accx_pkg::DATA_W,
    parameter int IDX_W  = accx_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [2:0]        op_code,
    input  logic              to_rf,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [DATA_W-1:0] result,
    output logic              acc_we,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic              flag_c,
    output logic              flag_dc,
    output logic              flag_z
);
    import accx_pkg::*;

    accx_op_e          op;
    logic [DATA_W-1:0] sub_min;
    logic [DATA_W-1:0] sub_diff;
    logic              sub_nb, sub_nbh, sub_zero;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [1:0]        sh_mode;
    logic              op_valid;
    accx_flags_t       f_nxt, f_upd, f_cur;

    assign op = accx_op_e'(op_code);

    // Minuend comes from the immediate or from the register operand.
    assign sub_min = (op == OP_SUBI) ? imm_val : rf_rdata;

    accx_sub #(.DATA_W(DATA_W)) u_sub (
        .min_i     (sub_min),
        .sub_i     (acc_val),
        .diff_o    (sub_diff),
        .nb_full_o (sub_nb),
        .nb_half_o (sub_nbh),
        .zero_o    (sub_zero)
    );

    // Map operation to shifter mode.
    always_comb begin
        case (op)
            OP_ROTL: sh_mode = 2'd0;
            OP_ROTR: sh_mode = 2'd1;
            default: sh_mode = 2'd2;
        endcase
    end

    accx_shift #(.DATA_W(DATA_W)) u_shift (
        .src_i  (rf_rdata),
        .cin_i  (f_cur.c),
        .mode_i (sh_mode),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    // Result, flag candidates and flag enables per operation.
    always_comb begin
        op_valid = 1'b1;
        result   = '0;
        f_nxt    = f_cur;
        f_upd    = '0;
        case (op)
            OP_SUBI, OP_SUBR: begin
                result = sub_diff;
                f_nxt  = '{c: sub_nb, dc: sub_nbh, z: sub_zero};
                f_upd  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            end
            OP_ROTL, OP_ROTR: begin
                result  = sh_res;
                f_nxt.c = sh_cout;
                f_upd.c = 1'b1;
            end
            OP_SWAP: begin
                result = sh_res;
            end
            default: op_valid = 1'b0;
        endcase
    end

    // Destination routing: immediate subtract always targets the accumulator.
    always_comb begin
        acc_we = exec_en && op_valid && ((op == OP_SUBI) || !to_rf);
        rf_we  = exec_en && op_valid && (op != OP_SUBI) && to_rf;
    end

    assign rf_waddr = src_idx;

    accx_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (exec_en),
        .nxt_i (f_nxt),
        .upd_i (f_upd),
        .cur_o (f_cur)
    );

    assign flag_c  = f_cur.c;
    assign flag_dc = f_cur.dc;
    assign flag_z  = f_cur.z;
endmodule

// File: rtl/accx_unit_chk.sv
// Property checker for accx_unit, attached by bind. Observes ports only.
module accx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_en,
    input logic [2:0] op_code,
    input logic       to_rf,
    input logic [7:0] rf_rdata,
    input logic [7:0] result,
    input logic       acc_we,
    input logic       rf_we,
    input logic [6:0] src_idx,
    input logic [6:0] rf_waddr,
    input logic       flag_c,
    input logic       flag_dc,
    input logic       flag_z
);
    AST_SUBI_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_code == 3'd0) |-> (acc_we && !rf_we)); // R1
    AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && rf_we)); // R2
    AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_code == 3'd2) |=> (flag_c == $past(rf_rdata[7]))); // R6
    AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_code == 3'd3) |=> (flag_c == $past(rf_rdata[0]))); // R7
    AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_code == 3'd4) |=> $stable({flag_c, flag_dc, flag_z})); // R8
    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable({flag_c, flag_dc, flag_z})); // R9
    AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 3'd4) |-> (!acc_we && !rf_we)); // R10
    AST_WADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_waddr == src_idx); // R11
    AST_SWAP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd4) |-> (result == {rf_rdata[3:0], rf_rdata[7:4]})); // R8
endmodule

bind accx_unit accx_unit_chk u_accx_unit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .op_code  (op_code),
    .to_rf    (to_rf),
    .rf_rdata (rf_rdata),
    .result   (result),
    .acc_we   (acc_we),
    .rf_we    (rf_we),
    .src_idx  (src_idx),
    .rf_waddr (rf_waddr),
    .flag_c   (flag_c),
    .flag_dc  (flag_dc),
    .flag_z   (flag_z)
);

// File: tb/accx_unit_bench.sv
// Directed bench for accx_unit with a register-file and accumulator model.
module accx_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic       to_rf = 1'b0;
    logic [7:0] acc_val = 8'd0;
    logic [7:0] imm_val = 8'd0;
    logic [6:0] src_idx = 7'd0;
    logic [7:0] rf_rdata = 8'd0;
    logic [7:0] result;
    logic       acc_we, rf_we;
    logic [6:0] rf_waddr;
    logic       flag_c, flag_dc, flag_z;

    logic [7:0] rf_mem [128];
    logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    accx_unit u_accx_unit (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
        .to_rf(to_rf), .acc_val(acc_val), .imm_val(imm_val),
        .src_idx(src_idx), .rf_rdata(rf_rdata), .result(result),
        .acc_we(acc_we), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One instruction: drive at negedge, check outputs, clock, check flags.
    task automatic run_op(input logic [2:0] op, input logic d, input logic [6:0] idx,
                          input logic [7:0] k, input logic en, input string tag);
        logic [7:0] src, exp_res;
        logic       e_c, e_dc, e_z, e_aw, e_rw, valid;
        @(negedge clk);
        exec_en = en; op_code = op; to_rf = d; src_idx = idx; imm_val = k;
        rf_rdata = rf_mem[idx];
        #1;
        src = (op == 3'd0) ? k : rf_mem[idx];
        e_c = m_c; e_dc = m_dc; e_z = m_z; valid = 1'b1; exp_res = 8'd0;
        case (op)
            3'd0, 3'd1: begin
                exp_res = src - acc_val;
                e_c  = (src >= acc_val);
                e_dc = (src[3:0] >= acc_val[3:0]);
                e_z  = (exp_res == 8'd0);
            end
            3'd2: begin exp_res = {src[6:0], m_c}; e_c = src[7]; end
            3'd3: begin exp_res = {m_c, src[7:1]}; e_c = src[0]; end
            3'd4: exp_res = {src[3:0], src[7:4]};
            default: valid = 1'b0;
        endcase
        e_aw = en && valid && (op == 3'd0 || !d);
        e_rw = en && valid && op != 3'd0 && d;
        if (valid) check(result == exp_res, {tag, " result"}, result, exp_res);
        check(acc_we == e_aw, {tag, " acc_we"}, acc_we, e_aw);
        check(rf_we == e_rw, {tag, " rf_we"}, rf_we, e_rw);
        check(rf_waddr == idx, "R11 rf_waddr", rf_waddr, idx);
        @(posedge clk);
        #1;
        if (en && valid) begin
            m_c = e_c; m_dc = e_dc; m_z = e_z;
            if (e_aw) acc_val = exp_res;
            if (e_rw) rf_mem[idx] = exp_res;
        end
        check({flag_c, flag_dc, flag_z} == {m_c, m_dc, m_z}, {tag, " flags"},
              {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z});
    endtask

    // Steer the accumulator to a chosen value via immediate subtract.
    task automatic set_acc(input logic [7:0] v);
        run_op(3'd0, 1'b0, 7'd0, v + acc_val, 1'b1, "R1 set_acc");
    endtask

    task automatic t_reset;
        check({flag_c, flag_dc, flag_z} == 3'b000, "R9 reset flags",
              {flag_c, flag_dc, flag_z}, 0);
        check(!acc_we && !rf_we, "R10 reset no write", {acc_we, rf_we}, 0);
    endtask

    task automatic t_subi;
        set_acc(8'h10);
        run_op(3'd0, 1'b1, 7'd3, 8'h10, 1'b1, "R1 R5 equal");      // zero, C=1, DC=1
        set_acc(8'h01);
        run_op(3'd0, 1'b0, 7'd3, 8'h00, 1'b1, "R1 R3 borrow");     // 0xFF, C=0, DC=0
        set_acc(8'h08);
        run_op(3'd0, 1'b0, 7'd3, 8'h37, 1'b1, "R3 R4 half borrow"); // C=1, DC=0
        set_acc(8'h21);
        run_op(3'd0, 1'b0, 7'd3, 8'h15, 1'b1, "R3 R4 full borrow"); // C=0, DC=1
    endtask

    task automatic t_subr;
        set_acc(8'h05);
        run_op(3'd1, 1'b0, 7'd10, 8'h00, 1'b1, "R2 to acc");
        set_acc(8'h03);
        run_op(3'd1, 1'b1, 7'd127, 8'h00, 1'b1, "R2 to rf");
        set_acc(rf_mem[20]);
        run_op(3'd1, 1'b1, 7'd20, 8'h00, 1'b1, "R2 R5 zero");
        set_acc(8'hF0);
        run_op(3'd1, 1'b0, 7'd0, 8'h00, 1'b1, "R2 R3 R4 small");
    endtask

    task automatic t_rotate;
        rf_mem[40] = 8'h81;
        set_acc(8'h01);
        run_op(3'd0, 1'b0, 7'd0, 8'h00, 1'b1, "R3 carry clear");
        run_op(3'd2, 1'b1, 7'd40, 8'h00, 1'b1, "R6 rotl c0");
        run_op(3'd2, 1'b1, 7'd40, 8'h00, 1'b1, "R6 rotl c1");
        run_op(3'd4, 1'b1, 7'd41, 8'h00, 1'b1, "R8 swap between");
        run_op(3'd3, 1'b1, 7'd40, 8'h00, 1'b1, "R7 rotr");
        run_op(3'd6, 1'b1, 7'd40, 8'h00, 1'b1, "R10 reserved between");
        run_op(3'd3, 1'b0, 7'd40, 8'h00, 1'b1, "R7 rotr to acc");
        run_op(3'd2, 1'b0, 7'd55, 8'h00, 1'b1, "R6 rotl to acc");
    endtask

    task automatic t_swap;
        rf_mem[60] = 8'hA5;
        run_op(3'd4, 1'b1, 7'd60, 8'h00, 1'b1, "R8 swap rf");
        run_op(3'd4, 1'b0, 7'd61, 8'h00, 1'b1, "R8 swap acc");
    endtask

    task automatic t_idle;
        run_op(3'd5, 1'b0, 7'd2, 8'h00, 1'b1, "R10 code5");
        run_op(3'd7, 1'b1, 7'd2, 8'h00, 1'b1, "R10 code7");
        run_op(3'd0, 1'b0, 7'd2, 8'h77, 1'b0, "R9 R10 strobe low subi");
        run_op(3'd2, 1'b1, 7'd2, 8'h00, 1'b0, "R9 R10 strobe low rotl");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) rf_mem[i] = 8'((i * 37 + 11) % 256);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_subi();
        t_subr();
        t_rotate();
        t_swap();
        t_idle();
        done = 1'b1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
        end
    end

    initial begin
        wait (done || n_bad < 0);
        #1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20001) @(posedge clk);
        #1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule